// File: doc/BRIEF.md
# Page Buffer Load Timer

This block gathers byte writes aimed at one page of a byte-wide nonvolatile memory model and decides on its own when the internal program cycle begins. Each write strobe brings a 16-bit address and an 8-bit value. The low seven address bits pick a column in a 128-byte page buffer, and a loaded flag is kept for each column. Nothing commands the commit. It starts when the strobes stop: once a set number of microsecond ticks pass after the last accepted strobe with no new one, the block enters a timed internal write. When that write ends, the whole page goes into a behavioural array in a single step.

The page that is written comes from the address of the most recent byte. Any column not loaded in the current phase is written as FFh. `busy` is high for the whole internal write, and strobes that arrive in that time are dropped. The address and data of the last accepted byte are driven out for the status logic next to this block. Both time limits are counted in ticks and are parameters, so a simulation can use short values.

Top module: `page_load_timer`

## Requirements
- R1: After reset, `busy` is 0, `last_addr` and `last_data` are 0, and every array location reads FFh.
- R2: An accepted strobe stores `wr_data` in buffer column `wr_addr[6:0]` and marks that column as loaded. Address bits 15:7 give the page.
- R3: While strobes keep arriving with fewer than LOAD_TMO ticks between them, the load phase stays open and `busy` stays 0. With no tick, `busy` never rises.
- R4: On the clock edge that registers the LOAD_TMO-th tick after the last accepted strobe, with no strobe in that cycle, `busy` goes to 1.
- R5: Loading a column a second time in the same phase replaces the value held for it.
- R6: The commit targets the page of the last accepted byte. Other pages keep their contents.
- R7: Columns not loaded in the phase are written as FFh, overwriting what the page held before.
- R8: `busy` stays 1 until the WR_TICKS-th tick of the write. On that edge `busy` drops and the whole page appears in the array at once. Before that edge the array still shows its old contents.
- R9: Strobes that arrive while `busy` is 1 are ignored. They change neither `last_addr`/`last_data` nor the buffer, and they do not open a load phase.
- R10: The first accepted strobe after idle clears every loaded flag, so bytes from an earlier phase are not written again.
- R11: `last_addr` and `last_data` hold the address and data of the most recent accepted strobe.
- R12: The array model holds MODEL_PAGES pages. A page number, both on write and on read through `rd_addr`, is taken modulo MODEL_PAGES using address bits 7 and up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_stb | input | 1 | Byte write strobe, one cycle |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| busy | output | 1 | Internal write in progress |
| last_addr | output | 16 | Address of last accepted byte |
| last_data | output | 8 | Data of last accepted byte |

## Verification
The bench places gaps of exactly LOAD_TMO-1 ticks between bytes, then exactly LOAD_TMO ticks. A design whose timeout is off by one would either commit in the middle of a page or wait one tick too long. Pages are reloaded with fewer bytes than the previous phase used. A design that forgets to clear its loaded flags would write stale bytes where FFh is due. A phase that ends on a different page from where it began catches a design that latches the first byte's page. Strobes sent during the write, and reads taken one tick before the write ends, expose designs that accept data while busy or commit too early.

// File: rtl/plt_pkg.sv
package plt_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int COL_W  = 7;
  localparam int COLS   = 1 << COL_W;
  localparam int PAGE_W = ADDR_W - COL_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WRITE} plt_state_e;

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction
endpackage

// File: rtl/plt_tick_timer.sv
module plt_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && !clear && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || expire)  cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  // R4 / R8: the count never passes the active limit
  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/plt_page_buffer.sv
module plt_page_buffer
  import plt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   new_phase,
  input  logic [COL_W-1:0]       col,
  input  logic [DATA_W-1:0]      data,
  output logic [COLS*DATA_W-1:0] page_data,
  output logic [COLS-1:0]        page_valid
);
  logic [DATA_W-1:0] data_q [COLS];
  logic [COLS-1:0]   valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < COLS; i++) data_q[i] <= '0;
    end else if (load) begin
      data_q[col] <= data;
      if (new_phase) begin
        valid_q      <= '0;
        valid_q[col] <= 1'b1;
      end else begin
        valid_q[col] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < COLS; g++) begin : g_flat
    assign page_data[g*DATA_W +: DATA_W] = data_q[g];
  end
  assign page_valid = valid_q;

  // R2: a loaded column is flagged on the next cycle
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> page_valid[$past(col)]);
  // R10: a fresh phase leaves exactly one flag set
  assert_phase_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && new_phase) |=> ($countones(page_valid) == 1));
endmodule

// File: rtl/plt_array_model.sv
module plt_array_model
  import plt_pkg::*;
#(
  parameter int PAGES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [ADDR_W-1:0]      wr_page_addr,
  input  logic [COLS*DATA_W-1:0] page_data,
  input  logic [COLS-1:0]        page_valid,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data
);
  localparam int SLOT_W = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int DEPTH  = PAGES * COLS;
  localparam int IDX_W  = SLOT_W + COL_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [SLOT_W-1:0] wr_slot;
  logic [IDX_W-1:0]  rd_idx;

  assign wr_slot = wr_page_addr[COL_W +: SLOT_W];
  assign rd_idx  = {rd_addr[COL_W +: SLOT_W], col_of(rd_addr)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int c = 0; c < COLS; c++)
        mem[{wr_slot, COL_W'(c)}] <= page_valid[c] ? page_data[c*DATA_W +: DATA_W] : '1;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/page_load_timer.sv
module page_load_timer
  import plt_pkg::*;
#(
  parameter int LOAD_TMO    = 200,
  parameter int WR_TICKS    = 5000,
  parameter int MODEL_PAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              wr_stb,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [15:0]       rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [15:0]       last_addr,
  output logic [7:0]        last_data
);
  localparam int MAX_LIM = (LOAD_TMO > WR_TICKS) ? LOAD_TMO : WR_TICKS;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  plt_state_e state;
  logic wr_acc, new_phase, tmr_clear, tmr_expire, start_write, commit;
  logic [CNT_W-1:0] tmr_limit;
  logic [COLS*DATA_W-1:0] page_data;
  logic [COLS-1:0] page_valid;

  // named internal events
  assign wr_acc      = wr_stb && (state != ST_WRITE);
  assign new_phase   = wr_acc && (state == ST_IDLE);
  assign tmr_clear   = wr_acc || (state == ST_IDLE);
  assign tmr_limit   = (state == ST_WRITE) ? CNT_W'(WR_TICKS) : CNT_W'(LOAD_TMO);
  assign start_write = (state == ST_LOAD) && tmr_expire;
  assign commit      = (state == ST_WRITE) && tmr_expire;
  assign busy        = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (wr_acc) begin
        last_addr <= wr_addr;
        last_data <= wr_data;
      end
      case (state)
        ST_IDLE:  if (wr_acc) state <= ST_LOAD;
        ST_LOAD:  if (start_write) state <= ST_WRITE;
        ST_WRITE: if (commit) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  plt_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .tick(us_tick),
    .limit(tmr_limit), .expire(tmr_expire)
  );

  plt_page_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .load(wr_acc), .new_phase(new_phase),
    .col(col_of(wr_addr)), .data(wr_data),
    .page_data(page_data), .page_valid(page_valid)
  );

  plt_array_model #(.PAGES(MODEL_PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_page_addr(last_addr),
    .page_data(page_data), .page_valid(page_valid),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R4: the write only begins on a tick with no strobe in that cycle
  assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(us_tick) && !$past(wr_stb)));
  // R3: without a tick, an idle or loading block stays out of the write
  assert_no_tick_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !us_tick) |=> !busy);
  // R8: the write cannot end except on a tick
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick) |=> busy);
  // R9: strobes during the write leave the reported byte untouched
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> ($stable(last_addr) && $stable(last_data)));
  // R11: an accepted strobe is reported next cycle
  assert_last_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy) |=> (last_addr == $past(wr_addr) && last_data == $past(wr_data)));
endmodule

// File: tb/tb_page_load_timer.sv
module tb_page_load_timer;
  localparam int LT = 4;
  localparam int WT = 6;
  localparam int PG = 8;
  localparam int NV = 9;
  localparam logic [3:0] END_PH = 4'hF;

  // {address, data, gap ticks or END_PH}
  localparam logic [27:0] VEC [NV] = '{
    {16'h0085, 8'hAA, 4'd3},
    {16'h0086, 8'hBB, 4'd0},
    {16'h0085, 8'hCC, 4'd2},
    {16'h0105, 8'hDD, END_PH},
    {16'h0200, 8'h11, 4'd1},
    {16'h027F, 8'h22, 4'd3},
    {16'h0201, 8'h33, END_PH},
    {16'h0100, 8'h44, END_PH},
    {16'h0480, 8'h55, END_PH}
  };

  logic clk = 0, rst_n = 0, us_tick = 0, wr_stb = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0, last_addr;
  logic [7:0] wr_data = 0, rd_data, last_data;
  logic busy;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] exp_mem [PG*128];
  logic [7:0] pend_d [128];
  bit pend_v [128];
  bit in_phase = 0;
  logic [15:0] exp_last_a = 0;
  logic [7:0]  exp_last_d = 0;

  always #5 clk = ~clk;

  page_load_timer #(.LOAD_TMO(LT), .WR_TICKS(WT), .MODEL_PAGES(PG)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .last_addr(last_addr), .last_data(last_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] a, input logic [7:0] d, input bit track);
    @(negedge clk); wr_stb = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_stb = 0;
    if (track) begin
      if (!in_phase) begin
        for (int c = 0; c < 128; c++) pend_v[c] = 0;
        in_phase = 1;
      end
      pend_d[a[6:0]] = d; pend_v[a[6:0]] = 1;
      exp_last_a = a; exp_last_d = d;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1;
      @(negedge clk); us_tick = 0;
    end
  endtask

  task automatic shadow_commit();
    int slot;
    slot = int'(exp_last_a[9:7]) % PG;
    for (int c = 0; c < 128; c++)
      exp_mem[slot*128 + c] = pend_v[c] ? pend_d[c] : 8'hFF;
    in_phase = 0;
  endtask

  task automatic check_array(input string req);
    int errs = 0, fa = 0, fv = 0, fe = 0;
    for (int i = 0; i < PG*128; i++) begin
      rd_addr = 16'(i); #1;
      if (rd_data !== exp_mem[i]) begin
        if (errs == 0) begin fa = i; fv = rd_data; fe = exp_mem[i]; end
        errs++;
      end
    end
    if (errs != 0) $display("FAIL %s first bad location %0h", req, fa);
    chk(errs == 0, req, fv, fe);
  endtask

  task automatic end_phase(input string req);
    ticks(LT - 1);
    chk(busy === 1'b0, "R4 one tick short of timeout", busy, 0);
    ticks(1);
    chk(busy === 1'b1, "R4 busy at timeout", busy, 1);
    ticks(WT - 1);
    chk(busy === 1'b1, "R8 busy before last tick", busy, 1);
    check_array("R8 array unchanged while busy");
    ticks(1);
    chk(busy === 1'b0, "R8 busy drops", busy, 0);
    shadow_commit();
    check_array(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PG*128; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(last_addr === 16'h0 && last_data === 8'h0, "R1 last byte", last_addr, 0);
    check_array("R1 array erased");

    // table walk: R2 R3 R5 R6 R7 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v][27:12], VEC[v][11:4], 1);
      chk(last_addr === exp_last_a && last_data === exp_last_d,
          "R11 last byte reported", last_addr, exp_last_a);
      if (VEC[v][3:0] == END_PH) begin
        end_phase("R2 R5 R6 R7 R10 R12 page commit");
      end else begin
        ticks(int'(VEC[v][3:0]));
        chk(busy === 1'b0, "R3 phase open", busy, 0);
      end
    end

    // R12: page 9 reads back through the alias of page 1
    rd_addr = 16'h0080; #1;
    chk(rd_data === 8'h55, "R12 modulo page read", rd_data, 8'h55);

    // R3: no ticks at all keeps the phase open for many cycles
    strobe(16'h0300, 8'h66, 1);
    repeat (50) @(negedge clk);
    chk(busy === 1'b0, "R3 no tick no start", busy, 0);
    ticks(LT);
    chk(busy === 1'b1, "R4 busy after timeout", busy, 1);

    // R9: strobes during the write are ignored
    strobe(16'h0305, 8'h77, 0);
    chk(last_addr === 16'h0300 && last_data === 8'h66, "R9 last byte kept", last_addr, 16'h0300);
    ticks(WT);
    chk(busy === 1'b0, "R9 write ends", busy, 0);
    shadow_commit();
    check_array("R9 ignored byte absent");
    ticks(2*LT);
    chk(busy === 1'b0, "R9 no phase opened", busy, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule